// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page mappings for a 32-bit virtual address space with 4 KB pages. A lookup presents a virtual address. The 20-bit virtual page number is compared against every resident entry at once, and a hit is answered within the same cycle. The answer is an 18-bit physical page number joined to the 12-bit page offset, which passes through unchanged, for a 30-bit physical address. A hit also marks the entry as referenced. A hit by a store also marks the entry as modified.

A lookup that misses raises a registered refill request that carries the missing page number. The request stays up until an external page-table walker answers. If the answer says the page is present, the mapping is installed. The slot is the lowest-numbered empty slot if one exists. Otherwise the slot is picked by a free-running pseudo-random sequence. When a resident mapping is displaced, its page number and its referenced and modified flags are reported for one cycle, so that they can be written back to the page table. If the answer says the page is absent, a page-fault pulse is raised and nothing is installed. A flush input invalidates every entry.

Top module: `xlat_buffer`

## Requirements
- R1: While `lkp_valid_i` is high and the page number in bits 31..12 of `lkp_vaddr_i` matches a resident entry, `lkp_hit_o` is high in the same cycle. In that case `lkp_paddr_o` equals the entry's physical page number in bits 29..12, with bits 11..0 copied from the virtual address. With no match, `lkp_hit_o` is low.
- R2: A lookup that misses with no request outstanding raises `req_valid_o` one cycle later, with `req_vpn_o` set to the missing page number. Both hold unchanged, even across further misses, until a response is taken.
- R3: A response (`resp_valid_i`) with `resp_present_i` high, taken while a request is outstanding, installs that page with `resp_ppn_i`. The request drops the next cycle, and later lookups of the page hit.
- R4: A response with `resp_present_i` low produces a one-cycle `fault_o` pulse and drops the request. It installs nothing and reports no eviction.
- R5: While at least one slot is empty, an install goes to an empty slot, and `evict_valid_o` stays low.
- R6: With all slots full, an install displaces exactly one resident page. `evict_valid_o` pulses for one cycle, the cycle after the response, with that page on `evict_vpn_o`. The displaced page then misses, and every other resident page still hits.
- R7: A newly installed entry starts with its referenced and modified flags clear. Any hit sets the referenced flag, and a hit with `lkp_store_i` high also sets the modified flag. On eviction the flags appear on `evict_ref_o` and `evict_dirty_o`.
- R8: `flush_i` invalidates every entry and cancels any outstanding request, so all later lookups miss until pages are refilled.
- R9: A response that arrives with no request outstanding is ignored. It raises no fault, reports no eviction and installs nothing.
- R10: After reset no lookup hits, and `req_valid_o`, `fault_o` and `evict_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all entries |
| lkp_valid_i | input | 1 | Lookup strobe |
| lkp_store_i | input | 1 | Lookup is a store |
| lkp_vaddr_i | input | 32 | Virtual address |
| lkp_hit_o | output | 1 | Combinational hit |
| lkp_paddr_o | output | 30 | Physical address on a hit |
| req_valid_o | output | 1 | Refill request outstanding |
| req_vpn_o | output | 20 | Page number to be walked |
| resp_valid_i | input | 1 | Walker response strobe |
| resp_present_i | input | 1 | Page-table entry valid |
| resp_ppn_i | input | 18 | Physical page number from the walker |
| fault_o | output | 1 | Page-fault pulse |
| evict_valid_o | output | 1 | Eviction report pulse |
| evict_vpn_o | output | 20 | Evicted page number |
| evict_ref_o | output | 1 | Evicted referenced flag |
| evict_dirty_o | output | 1 | Evicted modified flag |

## Verification
A directed fill of sixteen distinct pages, at varied offsets, shows that empty slots are used before anything is displaced. It also checks that offsets pass through untouched. A flush followed by a second fill separates true invalidation from stale tags. A fault response, followed by an unsolicited response, tells an ignored answer apart from a silently installed one. A second miss while a request is pending shows that the request is held. A long stream of random loads and stores over a page pool larger than the buffer forces many random evictions. Each eviction report is compared against a bench model of the resident set and of which pages were referenced or stored to.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VA_W  = 32;
  parameter int PA_W  = 30;
  parameter int OFS_W = 12;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
endpackage

// File: rtl/xlat_lfsr.sv
module xlat_lfsr #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    TAPS  = 16'hB400,
  parameter logic [W-1:0]    SEED  = 16'h0001,
  parameter int              OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else state <= state >> 1;
  end

  assign rnd_o = state[OUT_W-1:0];
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int N     = 16,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][VPN_W-1:0] tag_i,
  input  logic [N-1:0][PPN_W-1:0] ppn_i,
  input  logic [VPN_W-1:0]        key_i,
  output logic [N-1:0]            match_o,
  output logic                    hit_o,
  output logic [IW-1:0]           idx_o,
  output logic [PPN_W-1:0]        ppn_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match_o[g] = vld_i[g] && (tag_i[g] == key_i);
    end
  endgenerate

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    ppn_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) begin
        idx_o = IW'(i);
        ppn_o = ppn_o | ppn_i[i];
      end
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N   = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vld_i,
  input  logic [IW-1:0] rnd_i,
  output logic [IW-1:0] idx_o,
  output logic          occupied_o
);
  logic          any_free;
  logic [IW-1:0] free_idx;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign idx_o      = any_free ? free_idx : rnd_i;
  assign occupied_o = vld_i[idx_o];
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int                 ENTRIES = 16,
  parameter int                 RND_W   = 16,
  parameter logic [RND_W-1:0]   RND_TAP = 16'hB400,
  parameter logic [RND_W-1:0]   RND_SEED = 16'h0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             lkp_valid_i,
  input  logic             lkp_store_i,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  output logic             lkp_hit_o,
  output logic [PA_W-1:0]  lkp_paddr_o,
  output logic             req_valid_o,
  output logic [VPN_W-1:0] req_vpn_o,
  input  logic             resp_valid_i,
  input  logic             resp_present_i,
  input  logic [PPN_W-1:0] resp_ppn_i,
  output logic             fault_o,
  output logic             evict_valid_o,
  output logic [VPN_W-1:0] evict_vpn_o,
  output logic             evict_ref_o,
  output logic             evict_dirty_o
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            ent_vld, ent_ref, ent_dirty;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;

  logic [VPN_W-1:0]   lkp_vpn;
  logic [ENTRIES-1:0] cam_match;
  logic               cam_hit;
  logic [IW-1:0]      cam_idx;
  logic [PPN_W-1:0]   cam_ppn;
  logic [IW-1:0]      rnd_idx, vic_idx;
  logic               vic_occupied;
  logic               do_fill, do_inst, do_req;

  assign lkp_vpn = lkp_vaddr_i[VA_W-1:OFS_W];

  xlat_cam #(.N(ENTRIES)) u_cam (
    .vld_i   (ent_vld),
    .tag_i   (ent_tag),
    .ppn_i   (ent_ppn),
    .key_i   (lkp_vpn),
    .match_o (cam_match),
    .hit_o   (cam_hit),
    .idx_o   (cam_idx),
    .ppn_o   (cam_ppn)
  );

  xlat_lfsr #(.W(RND_W), .TAPS(RND_TAP), .SEED(RND_SEED), .OUT_W(IW)) u_rnd (
    .clk   (clk),
    .rst   (rst),
    .rnd_o (rnd_idx)
  );

  xlat_victim #(.N(ENTRIES)) u_vic (
    .vld_i      (ent_vld),
    .rnd_i      (rnd_idx),
    .idx_o      (vic_idx),
    .occupied_o (vic_occupied)
  );

  assign lkp_hit_o   = lkp_valid_i && cam_hit;
  assign lkp_paddr_o = {cam_ppn, lkp_vaddr_i[OFS_W-1:0]};

  assign do_fill = resp_valid_i && req_valid_o && !flush_i;
  assign do_inst = do_fill && resp_present_i;
  assign do_req  = lkp_valid_i && !cam_hit && !req_valid_o && !flush_i && !do_fill;

  // request, fault and eviction report registers
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_o   <= 1'b0;
      req_vpn_o     <= '0;
      fault_o       <= 1'b0;
      evict_valid_o <= 1'b0;
      evict_vpn_o   <= '0;
      evict_ref_o   <= 1'b0;
      evict_dirty_o <= 1'b0;
    end else begin
      fault_o       <= do_fill && !resp_present_i;
      evict_valid_o <= do_inst && vic_occupied;
      if (do_inst) begin
        evict_vpn_o   <= ent_tag[vic_idx];
        evict_ref_o   <= ent_ref[vic_idx];
        evict_dirty_o <= ent_dirty[vic_idx];
      end
      if (flush_i || do_fill) begin
        req_valid_o <= 1'b0;
      end else if (do_req) begin
        req_valid_o <= 1'b1;
        req_vpn_o   <= lkp_vpn;
      end
    end
  end

  // entry flags
  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      ent_vld   <= '0;
      ent_ref   <= '0;
      ent_dirty <= '0;
    end else begin
      if (lkp_hit_o) begin
        ent_ref[cam_idx] <= 1'b1;
        if (lkp_store_i) ent_dirty[cam_idx] <= 1'b1;
      end
      if (do_inst) begin
        ent_vld[vic_idx]   <= 1'b1;
        ent_ref[vic_idx]   <= 1'b0;
        ent_dirty[vic_idx] <= 1'b0;
      end
    end
  end

  // tag and translation storage, written only on install
  always_ff @(posedge clk) begin
    if (do_inst) begin
      ent_tag[vic_idx] <= req_vpn_o;
      ent_ppn[vic_idx] <= resp_ppn_i;
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               flush_i,
  input logic               resp_valid_i,
  input logic               req_valid_o,
  input logic [VPN_W-1:0]   req_vpn_o,
  input logic               fault_o,
  input logic               evict_valid_o,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] vld_vec
);
  p_single_match_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !resp_valid_i && !flush_i) |=> (req_valid_o && $stable(req_vpn_o)));

  p_fault_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!evict_valid_o && !req_valid_o));

  p_evict_full_r6: assert property (@(posedge clk) disable iff (rst)
    evict_valid_o |-> ($past($countones(vld_vec)) == ENTRIES));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (vld_vec == '0 && !req_valid_o));

  p_idle_resp_r9: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_i && !req_valid_o) |=> (!fault_o && !evict_valid_o));
endmodule

bind xlat_buffer xlat_buffer_chk #(.ENTRIES(ENTRIES), .VPN_W(xlat_pkg::VPN_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush_i       (flush_i),
  .resp_valid_i  (resp_valid_i),
  .req_valid_o   (req_valid_o),
  .req_vpn_o     (req_vpn_o),
  .fault_o       (fault_o),
  .evict_valid_o (evict_valid_o),
  .match_vec     (cam_match),
  .vld_vec       (ent_vld)
);

// File: tb/xlat_buffer_tb.sv
module xlat_buffer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic        lkp_store_i = 1'b0;
  logic [31:0] lkp_vaddr_i = '0;
  logic        lkp_hit_o;
  logic [29:0] lkp_paddr_o;
  logic        req_valid_o;
  logic [19:0] req_vpn_o;
  logic        resp_valid_i = 1'b0;
  logic        resp_present_i = 1'b0;
  logic [17:0] resp_ppn_i = '0;
  logic        fault_o, evict_valid_o, evict_ref_o, evict_dirty_o;
  logic [19:0] evict_vpn_o;

  int checks = 0;
  int errors = 0;

  logic [19:0] m_vpn [16];
  logic [17:0] m_ppn [16];
  bit          m_ref [16];
  bit          m_dirty [16];
  int          m_cnt = 0;

  always #4 clk = ~clk;

  xlat_buffer u_dut (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .lkp_valid_i(lkp_valid_i), .lkp_store_i(lkp_store_i), .lkp_vaddr_i(lkp_vaddr_i),
    .lkp_hit_o(lkp_hit_o), .lkp_paddr_o(lkp_paddr_o),
    .req_valid_o(req_valid_o), .req_vpn_o(req_vpn_o),
    .resp_valid_i(resp_valid_i), .resp_present_i(resp_present_i), .resp_ppn_i(resp_ppn_i),
    .fault_o(fault_o), .evict_valid_o(evict_valid_o), .evict_vpn_o(evict_vpn_o),
    .evict_ref_o(evict_ref_o), .evict_dirty_o(evict_dirty_o)
  );

  function automatic logic [17:0] ppn_of(input logic [19:0] v);
    logic [19:0] t;
    t = v ^ (v << 3) ^ 20'h2A5A5;
    return t[17:0];
  endfunction

  function automatic int find(input logic [19:0] v);
    for (int i = 0; i < m_cnt; i++) if (m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic m_remove(input int k);
    for (int i = k; i < m_cnt - 1; i++) begin
      m_vpn[i] = m_vpn[i+1]; m_ppn[i] = m_ppn[i+1];
      m_ref[i] = m_ref[i+1]; m_dirty[i] = m_dirty[i+1];
    end
    m_cnt--;
  endtask

  // combinational look, no clock edge while valid is high
  task automatic probe(input logic [19:0] v, input logic [11:0] off);
    int k;
    k = find(v);
    @(negedge clk);
    lkp_valid_i = 1'b1; lkp_store_i = 1'b0; lkp_vaddr_i = {v, off};
    #1;
    chk(lkp_hit_o == (k >= 0), "R1/R3/R6 probe hit", lkp_hit_o, k >= 0);
    if (k >= 0)
      chk(lkp_paddr_o == {m_ppn[k], off}, "R1 probe paddr", lkp_paddr_o, {m_ppn[k], off});
    #1;
    lkp_valid_i = 1'b0;
  endtask

  task automatic access(input logic [19:0] v, input logic [11:0] off, input bit st,
                        input bit pres, input bit poke);
    int k, e;
    k = find(v);
    @(negedge clk);
    lkp_valid_i = 1'b1; lkp_store_i = st; lkp_vaddr_i = {v, off};
    #1;
    chk(lkp_hit_o == (k >= 0), "R1 hit flag", lkp_hit_o, k >= 0);
    if (k >= 0)
      chk(lkp_paddr_o == {m_ppn[k], off}, "R1 paddr", lkp_paddr_o, {m_ppn[k], off});
    @(posedge clk);
    if (k >= 0) begin
      m_ref[k] = 1'b1;
      if (st) m_dirty[k] = 1'b1;
    end
    @(negedge clk);
    lkp_valid_i = 1'b0; lkp_store_i = 1'b0;
    if (k < 0) begin
      #1;
      chk(req_valid_o && req_vpn_o == v, "R2 request raised", {req_valid_o, req_vpn_o}, {1'b1, v});
      if (poke) begin
        lkp_valid_i = 1'b1; lkp_vaddr_i = {20'hFFFFF, off};
        @(negedge clk);
        lkp_valid_i = 1'b0;
        #1;
        chk(req_valid_o && req_vpn_o == v, "R2 request held", {req_valid_o, req_vpn_o}, {1'b1, v});
      end
      resp_valid_i = 1'b1; resp_present_i = pres; resp_ppn_i = ppn_of(v);
      @(negedge clk);
      resp_valid_i = 1'b0;
      #1;
      if (pres) begin
        chk(!req_valid_o, "R3 request retired", req_valid_o, 0);
        if (m_cnt == 16) begin
          chk(evict_valid_o, "R6 eviction pulse", evict_valid_o, 1);
          e = find(evict_vpn_o);
          chk(e >= 0, "R6 evicted page was resident", evict_vpn_o, 0);
          if (e >= 0) begin
            chk(evict_ref_o == m_ref[e], "R7 evicted ref flag", evict_ref_o, m_ref[e]);
            chk(evict_dirty_o == m_dirty[e], "R7 evicted dirty flag", evict_dirty_o, m_dirty[e]);
            m_remove(e);
          end
        end else begin
          chk(!evict_valid_o, "R5 no eviction with free slot", evict_valid_o, 0);
        end
        if (m_cnt < 16) begin
          m_vpn[m_cnt] = v; m_ppn[m_cnt] = ppn_of(v);
          m_ref[m_cnt] = 1'b0; m_dirty[m_cnt] = 1'b0;
          m_cnt++;
        end
        @(negedge clk);
        #1;
        chk(!evict_valid_o, "R6 eviction pulse one cycle", evict_valid_o, 0);
      end else begin
        chk(fault_o, "R4 fault pulse", fault_o, 1);
        chk(!evict_valid_o, "R4 no eviction on fault", evict_valid_o, 0);
        chk(!req_valid_o, "R4 request retired", req_valid_o, 0);
      end
      probe(v, off);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    m_cnt = 0;
    #1;
    chk(!req_valid_o, "R8 request cancelled", req_valid_o, 0);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    logic [19:0] first_vpn;
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!req_valid_o && !fault_o && !evict_valid_o, "R10 reset outputs",
        {req_valid_o, fault_o, evict_valid_o}, 0);
    probe(20'h00123, 12'h456);

    // fill all slots, store to some, one held request
    for (int i = 0; i < 16; i++)
      access(20'h10000 + 20'(i * 3), 12'(i * 251), 1'b0, 1'b1, i == 5);
    for (int i = 0; i < 16; i += 2)
      access(20'h10000 + 20'(i * 3), 12'hFFF, i % 4 == 0, 1'b1, 1'b0);
    // full: next installs displace
    access(20'h20000, 12'h000, 1'b1, 1'b1, 1'b0);
    access(20'h20001, 12'h001, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) probe(20'h10000 + 20'(i * 3), 12'h0AB);

    // fault, then an unsolicited response must be ignored
    access(20'h30000, 12'h777, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    resp_valid_i = 1'b1; resp_present_i = 1'b1; resp_ppn_i = 18'h3FFFF;
    @(negedge clk);
    resp_valid_i = 1'b0;
    #1;
    chk(!fault_o && !evict_valid_o, "R9 unsolicited response ignored", {fault_o, evict_valid_o}, 0);
    probe(20'h30000, 12'h777);

    // flush, then refill without evictions
    first_vpn = m_vpn[0];
    do_flush();
    probe(first_vpn, 12'h010);
    probe(20'h20000, 12'h010);
    for (int i = 0; i < 16; i++)
      access(20'h50000 + 20'(i * 5), 12'(i), 1'b1, 1'b1, 1'b0);

    // random traffic over a pool larger than the buffer
    for (int n = 0; n < 500; n++) begin
      access(20'h40000 + 20'(($urandom % 40) * 17), 12'($urandom), 1'($urandom % 2),
             ($urandom % 10) != 0, 1'b0);
    end
    report();
  end
endmodule